// File: doc/BRIEF.md
# Channel-Status and User-Bit Double Buffer Manager

This block holds the per-block channel-status (C) and user (U) bit data for a digital audio transmitter. C and U each have their own complete pair of buffers. The host writes an "edit" buffer, and the transmit side reads a "frame" buffer. Each buffer is 24 bytes, which is the 192 bits of one audio block. At every block start, a sequencer copies the edit buffer into the frame buffer at one byte per clock cycle, unless that copy is inhibited. While a copy runs, the block raises a transfer interrupt source for it.

The host sees a 24-byte window at addresses 20h to 37h. A select input maps either the C edit buffer or the U edit buffer into that window. The U edit buffer can be reached only while the U manager is in block mode.

On every frame strobe the block presents one C bit and one U bit. The U bit comes from one of three places: an external U pin, the U frame buffer, or constant zero. This depends on the U source input and the U mode code.

Top module: `csub_buffer_mgr`

## Requirements
- R1: With `win_sel_u`=0, addresses 20h..37h read and write C edit byte (address-20h). A read at any address outside the window returns 0.
- R2: With `win_sel_u`=1, the window maps the U edit buffer only when `u_mode`=01 (block mode). With any other `u_mode`, window writes are ignored and window reads return 0.
- R3: When `c_inhibit`=1 at a block start, the C frame buffer keeps its contents for the whole next block. When `c_inhibit`=0, the C frame buffer takes the C edit contents.
- R4: A block is 192 frames. The `frame_tick` that follows frame 191 starts a new block at frame 0, and the first `frame_tick` after reset also starts a block. In frame n, `c_bit` is bit (n mod 8) of C frame byte n/8, so each byte is sent LSB first.
- R5: The U bit source works as follows:
  - With `u_src_buf`=0, `u_bit` equals `u_pin`.
  - With `u_src_buf`=1 and `u_mode`=01, `u_bit` is bit (n mod 8) of U frame byte n/8.
  - With `u_src_buf`=1 and any other `u_mode`, `u_bit` is 0.
- R6: After a block-start `frame_tick` edge, `c_xfer_irq` is high for exactly 24 consecutive cycles, starting in the following cycle, if the C copy is allowed. If the C copy is inhibited, it stays low. `u_xfer_irq` behaves the same way for the U copy.
- R7: The U copy happens only when `u_mode`=01 and `u_inhibit`=0 at the block start. Otherwise the U frame buffer is left unchanged.
- R8: A host write to an edit byte during a copy is kept. The copy takes the edit byte as it stands in the cycle the sequencer reads that byte, and byte k is read k cycles after the copy starts.
- R9: After reset, all buffers are zero, both interrupt sources are low, and the block sits at frame 191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 7 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_rdata | output | 8 | Host read data (combinational) |
| win_sel_u | input | 1 | Window select: 0 = C edit buffer, 1 = U edit buffer |
| c_inhibit | input | 1 | Block the C edit-to-frame copy |
| u_inhibit | input | 1 | Block the U edit-to-frame copy |
| u_mode | input | 2 | U manager mode: 00 = all zeros, 01 = block, 10/11 = reserved |
| u_src_buf | input | 1 | U source: 0 = U pin, 1 = U buffer manager |
| u_pin | input | 1 | External U data input |
| frame_tick | input | 1 | One-cycle pulse per audio frame |
| c_bit | output | 1 | C bit of the current frame |
| u_bit | output | 1 | U bit of the current frame |
| c_xfer_irq | output | 1 | C copy in progress |
| u_xfer_irq | output | 1 | U copy in progress |

## Verification
The bench sweeps all 192 bit positions of both buffers across several blocks. A design with swapped bit order, a wrong byte index or an off-by-one block boundary would therefore show wrong C or U bits at specific frames.

Each inhibit is toggled on its own, so that a design sharing one inhibit between C and U, or ignoring one, would update the wrong frame buffer. Writes in non-block U mode are checked twice: they must read back as 0 at once, and they must not appear later in block mode. This catches a decoder that ignores the mode.

A write to the last edit byte just after a copy starts must show up in frame bits 184..191 of the next block. This exposes a design that snapshots the edit buffer early or drops the colliding write. The interrupt pulses are counted cycle by cycle, so a copy of 23 or 25 cycles is reported.

// File: rtl/csub_pkg.sv
package csub_pkg;
  localparam int BUF_BYTES = 24;
  localparam int ADDR_W    = 7;
  localparam logic [ADDR_W-1:0] WIN_BASE = 7'h20;

  typedef enum logic [1:0] {
    UM_ZERO  = 2'b00,
    UM_BLOCK = 2'b01,
    UM_RSV2  = 2'b10,
    UM_RSV3  = 2'b11
  } u_mode_e;
endpackage

// File: rtl/csub_bank.sv
module csub_bank #(
  parameter int BYTES = 24,
  parameter int IDX_W = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  input  logic             cp_en,
  input  logic [IDX_W-1:0] cp_idx,
  input  logic [IDX_W-1:0] tx_byte,
  input  logic [2:0]       tx_bitpos,
  output logic             tx_bit
);
  logic [BYTES-1:0][7:0] e_q, e_d;
  logic [BYTES-1:0][7:0] f_q, f_d;

  always_comb begin
    e_d = e_q;
    if (wr_en) e_d[wr_idx] = wr_data;
  end

  always_comb begin
    f_d = f_q;
    if (cp_en) f_d[cp_idx] = e_q[cp_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q <= '0;
      f_q <= '0;
    end else begin
      if (wr_en) e_q <= e_d;
      if (cp_en) f_q <= f_d;
    end
  end

  assign rd_data = e_q[rd_idx];
  assign tx_bit  = f_q[tx_byte][tx_bitpos];

  // R3: frame buffer only changes on copy cycles
  p_frame_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cp_en |=> $stable(f_q));
  // R2: edit buffer only changes on decoded writes
  p_edit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(e_q));
endmodule

// File: rtl/csub_xfer_ctl.sv
module csub_xfer_ctl #(
  parameter int BYTES  = 24,
  parameter int IDX_W  = $clog2(BYTES),
  parameter int FRM_W  = IDX_W + 3,
  parameter int FRAMES = BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             c_allow,
  input  logic             u_allow,
  output logic [FRM_W-1:0] frame_idx,
  output logic [IDX_W-1:0] cp_idx,
  output logic             c_cp_en,
  output logic             u_cp_en
);
  localparam logic [FRM_W-1:0] LAST_FRM  = FRM_W'(FRAMES - 1);
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(BYTES - 1);

  logic [FRM_W-1:0] frm_q, frm_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cgo_q, cgo_d, ugo_q, ugo_d;
  logic             start;

  assign start = frame_tick && (frm_q == LAST_FRM);

  always_comb begin
    frm_d  = frm_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    cgo_d  = cgo_q;
    ugo_d  = ugo_q;
    if (frame_tick) frm_d = (frm_q == LAST_FRM) ? '0 : frm_q + 1'b1;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      cgo_d  = c_allow;
      ugo_d  = u_allow;
    end else if (busy_q) begin
      if (cnt_q == LAST_BYTE) busy_d = 1'b0;
      else                    cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q  <= LAST_FRM;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      cgo_q  <= 1'b0;
      ugo_q  <= 1'b0;
    end else begin
      frm_q  <= frm_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      cgo_q  <= cgo_d;
      ugo_q  <= ugo_d;
    end
  end

  assign frame_idx = frm_q;
  assign cp_idx    = cnt_q;
  assign c_cp_en   = busy_q && cgo_q;
  assign u_cp_en   = busy_q && ugo_q;

  // R4: block start launches the copy at byte 0
  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && cnt_q == '0 && frm_q == '0));
  // R6: copy index stays inside the buffer
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST_BYTE));
  // R6: copy ends after the last byte
  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST_BYTE && !start) |=> !busy_q);
  // R4: frame counter never leaves the block
  p_frame_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_q <= LAST_FRM);
endmodule

// File: rtl/csub_buffer_mgr.sv
module csub_buffer_mgr #(
  parameter int BYTES  = csub_pkg::BUF_BYTES,
  parameter int ADDR_W = csub_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_we,
  output logic [7:0]        host_rdata,
  input  logic              win_sel_u,
  input  logic              c_inhibit,
  input  logic              u_inhibit,
  input  logic [1:0]        u_mode,
  input  logic              u_src_buf,
  input  logic              u_pin,
  input  logic              frame_tick,
  output logic              c_bit,
  output logic              u_bit,
  output logic              c_xfer_irq,
  output logic              u_xfer_irq
);
  import csub_pkg::*;

  localparam int IDX_W  = $clog2(BYTES);
  localparam int FRM_W  = IDX_W + 3;
  localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + ADDR_W'(BYTES - 1);

  logic              in_win, u_blk;
  logic [ADDR_W-1:0] off_full;
  logic [IDX_W-1:0]  off;
  logic              c_wr, u_wr;
  logic [7:0]        c_rd, u_rd;
  logic [FRM_W-1:0]  frame_idx;
  logic [IDX_W-1:0]  cp_idx;
  logic              c_cp_en, u_cp_en;
  logic              c_tx, u_tx;

  assign in_win   = (host_addr >= WIN_BASE) && (host_addr <= WIN_LAST);
  assign off_full = host_addr - WIN_BASE;
  assign off      = off_full[IDX_W-1:0];
  assign u_blk    = (u_mode_e'(u_mode) == UM_BLOCK);
  assign c_wr     = host_we && in_win && !win_sel_u;
  assign u_wr     = host_we && in_win && win_sel_u && u_blk;

  always_comb begin
    host_rdata = 8'h00;
    if (in_win) begin
      if (!win_sel_u)  host_rdata = c_rd;
      else if (u_blk)  host_rdata = u_rd;
    end
  end

  csub_xfer_ctl #(.BYTES(BYTES), .IDX_W(IDX_W), .FRM_W(FRM_W)) i_ctl (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .c_allow(!c_inhibit), .u_allow(u_blk && !u_inhibit),
    .frame_idx(frame_idx), .cp_idx(cp_idx),
    .c_cp_en(c_cp_en), .u_cp_en(u_cp_en)
  );

  csub_bank #(.BYTES(BYTES), .IDX_W(IDX_W)) i_cbank (
    .clk(clk), .rst_n(rst_n), .wr_en(c_wr), .wr_idx(off), .wr_data(host_wdata),
    .rd_idx(off), .rd_data(c_rd), .cp_en(c_cp_en), .cp_idx(cp_idx),
    .tx_byte(frame_idx[FRM_W-1:3]), .tx_bitpos(frame_idx[2:0]), .tx_bit(c_tx)
  );

  csub_bank #(.BYTES(BYTES), .IDX_W(IDX_W)) i_ubank (
    .clk(clk), .rst_n(rst_n), .wr_en(u_wr), .wr_idx(off), .wr_data(host_wdata),
    .rd_idx(off), .rd_data(u_rd), .cp_en(u_cp_en), .cp_idx(cp_idx),
    .tx_byte(frame_idx[FRM_W-1:3]), .tx_bitpos(frame_idx[2:0]), .tx_bit(u_tx)
  );

  assign c_bit      = c_tx;
  assign u_bit      = u_src_buf ? (u_blk && u_tx) : u_pin;
  assign c_xfer_irq = c_cp_en;
  assign u_xfer_irq = u_cp_en;

  // R5: buffer source outside block mode sends zeros
  p_uzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (u_src_buf && !u_blk) |-> !u_bit);
  // R6: an interrupt source only rises right after a frame strobe
  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(c_xfer_irq) || $rose(u_xfer_irq)) |-> $past(frame_tick));
  // R7: the U copy is never active outside block mode at its start
  p_ucopy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(u_xfer_irq) |-> $past(u_blk && !u_inhibit));
endmodule

// File: tb/test_csub_buffer_mgr.sv
`timescale 1ns/1ps
module test_csub_buffer_mgr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] host_addr;
  logic [7:0] host_wdata;
  logic       host_we;
  logic [7:0] host_rdata;
  logic       win_sel_u, c_inhibit, u_inhibit, u_src_buf, u_pin, frame_tick;
  logic [1:0] u_mode;
  logic       c_bit, u_bit, c_xfer_irq, u_xfer_irq;

  int checks = 0;
  int failures = 0;

  logic [7:0] ec [24];
  logic [7:0] eu [24];
  logic [7:0] fc [24];
  logic [7:0] fu [24];

  always #4 clk = ~clk;

  csub_buffer_mgr i_csub_buffer_mgr (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_rdata(host_rdata), .win_sel_u(win_sel_u),
    .c_inhibit(c_inhibit), .u_inhibit(u_inhibit), .u_mode(u_mode),
    .u_src_buf(u_src_buf), .u_pin(u_pin), .frame_tick(frame_tick),
    .c_bit(c_bit), .u_bit(u_bit), .c_xfer_irq(c_xfer_irq), .u_xfer_irq(u_xfer_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * seed) + (seed * 3) + (i >> 1));
  endfunction

  task automatic host_wr(input logic [6:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_chk(input string req, input logic [6:0] a, input logic [7:0] exp);
    host_addr = a;
    #1;
    check(req, host_rdata, exp);
  endtask

  task automatic fill(input logic sel, input int seed);
    win_sel_u = sel;
    for (int i = 0; i < 24; i++) begin
      host_wr(7'(8'h20 + i), pat(seed, i));
      if (!sel) ec[i] = pat(seed, i);
      else if (u_mode == 2'b01) eu[i] = pat(seed, i);
    end
  endtask

  // block-start strobe; optionally a host write right after the copy starts
  task automatic block_start(input string req, input bit mid_wr, input logic sel,
                             input int widx, input logic [7:0] wd);
    int cc = 0;
    int cu = 0;
    int exp_c, exp_u;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    for (int k = 0; k < 30; k++) begin
      cc += int'(c_xfer_irq);
      cu += int'(u_xfer_irq);
      if (k == 0 && mid_wr) begin
        win_sel_u = sel; host_addr = 7'(8'h20 + widx); host_wdata = wd; host_we = 1'b1;
        if (!sel) ec[widx] = wd; else if (u_mode == 2'b01) eu[widx] = wd;
      end
      @(negedge clk);
      host_we = 1'b0;
    end
    exp_c = c_inhibit ? 0 : 24;
    exp_u = (u_mode == 2'b01 && !u_inhibit) ? 24 : 0;
    if (!c_inhibit) for (int i = 0; i < 24; i++) fc[i] = ec[i];
    if (exp_u != 0) for (int i = 0; i < 24; i++) fu[i] = eu[i];
    check({req, " R6 c_xfer_irq cycles"}, cc, exp_c);
    check({req, " R6 u_xfer_irq cycles"}, cu, exp_u);
  endtask

  task automatic run_block(input string req);
    logic eub;
    for (int n = 0; n < 192; n++) begin
      u_pin = n[0] ^ n[3] ^ n[5];
      #1;
      check({req, " R4 c_bit"}, c_bit, fc[n / 8][n % 8]);
      if (!u_src_buf) eub = u_pin;
      else if (u_mode == 2'b01) eub = fu[n / 8][n % 8];
      else eub = 1'b0;
      check({req, " R5 u_bit"}, u_bit, eub);
      if (n < 191) begin
        @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_addr = '0; host_wdata = '0; host_we = 1'b0;
    win_sel_u = 1'b0; c_inhibit = 1'b0; u_inhibit = 1'b0; u_mode = 2'b00;
    u_src_buf = 1'b0; u_pin = 1'b0; frame_tick = 1'b0;
    for (int i = 0; i < 24; i++) begin ec[i] = 0; eu[i] = 0; fc[i] = 0; fu[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 c_bit", c_bit, 0);
    check("R9 u_bit", u_bit, 0);
    check("R9 c_xfer_irq", c_xfer_irq, 0);
    check("R9 u_xfer_irq", u_xfer_irq, 0);
    host_chk("R9 C edit zero", 7'h25, 8'h00);

    // R1 / R2 window map
    u_mode = 2'b01;
    fill(1'b0, 37);
    fill(1'b1, 11);
    win_sel_u = 1'b0;
    for (int i = 0; i < 24; i++) host_chk("R1 C readback", 7'(8'h20 + i), ec[i]);
    host_chk("R1 below window", 7'h1F, 8'h00);
    host_chk("R1 above window", 7'h38, 8'h00);
    win_sel_u = 1'b1;
    for (int i = 0; i < 24; i++) host_chk("R2 U readback", 7'(8'h20 + i), eu[i]);

    // first block after reset, both copies
    u_src_buf = 1'b1;
    block_start("blk1", 1'b0, 1'b0, 0, 8'h00);
    run_block("blk1");

    // R3 C inhibit
    fill(1'b0, 53);
    fill(1'b1, 29);
    c_inhibit = 1'b1;
    block_start("R3 blk2", 1'b0, 1'b0, 0, 8'h00);
    run_block("R3 blk2");

    // R7 U inhibit
    c_inhibit = 1'b0; u_inhibit = 1'b1;
    fill(1'b1, 71);
    block_start("R7 blk3", 1'b0, 1'b0, 0, 8'h00);
    run_block("R7 blk3");

    // R2 / R7 non-block U mode
    u_inhibit = 1'b0; u_mode = 2'b00;
    win_sel_u = 1'b1;
    host_wr(7'h20, 8'hAA);
    host_chk("R2 U window read in zero mode", 7'h20, 8'h00);
    block_start("R7 blk4", 1'b0, 1'b0, 0, 8'h00);
    run_block("R5 blk4 zeros");
    u_mode = 2'b11;
    #1;
    check("R5 reserved mode u_bit", u_bit, 0);
    u_mode = 2'b01;
    host_chk("R2 U edit unchanged by ignored write", 7'h20, eu[0]);

    // R5 U pin source, R8 write during copy
    u_src_buf = 1'b0;
    block_start("R8 blk5", 1'b1, 1'b0, 23, 8'h5C);
    run_block("R8 blk5 pin");
    u_src_buf = 1'b1;
    block_start("R8 blk6", 1'b1, 1'b1, 23, 8'hC3);
    run_block("R8 blk6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule